// File: doc/BRIEF.md
# DC-Link Bypass Full-Bridge Gate Sequencer

This block produces the six gate commands for a single-phase full bridge that has one extra switch in each DC-link rail between the panel and the bridge. A signed sampled sine reference is compared in magnitude with an internal up/down triangular carrier. The result is unipolar PWM. In an active interval one diagonal pair of the bridge conducts together with both rail switches, so four devices are on. In a zero interval all six gates are off. The panel is then cut away from the bridge while the load current freewheels through external clamping paths. The rail switches therefore commutate at the carrier rate, not at line rate.

The half-cycle polarity comes from the sign of the reference. The reference is captured only when the carrier is at zero, so the polarity changes only at a carrier period boundary. Any turn-off of a gate opens all gates. After that, no gate turns on again until a programmable dead time has passed. Dropping the enable or raising the synchronous reset parks every gate low.

Top module: `dcbp_gate_seq`

## Requirements
- R1: The carrier counts 0, 1, ..., T, T-1, ..., 1, 0, 1, ... where T is `car_top` (T >= 1), so one carrier period is 2T clock cycles. The reference is captured on the edge at which the carrier is 0.
- R2: When the captured sign bit is 0 and the captured magnitude is greater than the carrier, the next edge turns on `g_pos_hi`, `g_pos_lo`, `g_link_p` and `g_link_n`. A steady magnitude m <= T yields 2m-1 active cycles per period. A magnitude above T yields continuous conduction.
- R3: When the captured sign bit is 1 and the captured magnitude is greater than the carrier, the next edge turns on `g_neg_hi`, `g_neg_lo`, `g_link_p` and `g_link_n`.
- R4: When the captured magnitude is not greater than the carrier (a zero interval), all six gates are low, including both rail switches. A zero reference yields no pulse at all.
- R5: `neg_half` equals the captured sign bit. It changes only on the edge after a cycle in which the carrier was 0, or when the block is idled.
- R6: No gate of the positive diagonal (`g_pos_hi`, `g_pos_lo`) is ever on in the same cycle as a gate of the negative diagonal (`g_neg_hi`, `g_neg_lo`).
- R7: When any gate turns off, every gate turns off. No gate then turns on for max(N,1) cycles, where N is `dead_len`. For the same reason a direct change between diagonals leaves exactly max(N,1) all-off cycles.
- R8: With `rst` high or `en` low, the next edge drives all gates and `neg_half` low and restarts the carrier at 0 counting up.
- R9: The most negative reference value is treated as the largest positive magnitude, 2^(REF_W-1)-1.
- R10: The two rail switches are always equal to each other. They are on exactly when a full diagonal pair is on, and the two gates of a diagonal always switch together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks all gates |
| ref_smp | input | REF_W | Signed sine reference sample |
| car_top | input | CNT_W | Carrier peak count T (half period) |
| dead_len | input | DT_W | Dead time N in clock cycles |
| g_pos_hi | output | 1 | Positive diagonal, upper device |
| g_pos_lo | output | 1 | Positive diagonal, lower device |
| g_neg_hi | output | 1 | Negative diagonal, upper device |
| g_neg_lo | output | 1 | Negative diagonal, lower device |
| g_link_p | output | 1 | Positive DC-rail switch |
| g_link_n | output | 1 | Negative DC-rail switch |
| neg_half | output | 1 | Captured half-cycle polarity, 1 = negative |

## Verification
All outputs are registered. A gate decision is due on the edge that ends the cycle holding the carrier value that caused it. A reference captured at the carrier-zero edge takes effect on the following edge, both for `neg_half` and for the comparison. The bench's behavioural model steps on each rising edge from the same inputs and compares every output at the falling edge, so each result is checked in the exact cycle it is due. Duty, period and dead-gap checks are made over whole carrier periods only after at least three periods have passed since the last input change.

// File: rtl/dcbp_pkg.sv
package dcbp_pkg;
   localparam int GATE_N = 6;

   // gate vector bit positions
   localparam int GB_POS_HI  = 0;
   localparam int GB_POS_LO  = 1;
   localparam int GB_NEG_HI  = 2;
   localparam int GB_NEG_LO  = 3;
   localparam int GB_LINK_P  = 4;
   localparam int GB_LINK_N  = 5;

   typedef logic [GATE_N-1:0] gate_vec_t;

   // conduction sets for the two active vectors (diagonal plus both rails)
   localparam gate_vec_t SET_POS = gate_vec_t'((1 << GB_POS_HI) | (1 << GB_POS_LO) |
                                               (1 << GB_LINK_P) | (1 << GB_LINK_N));
   localparam gate_vec_t SET_NEG = gate_vec_t'((1 << GB_NEG_HI) | (1 << GB_NEG_LO) |
                                               (1 << GB_LINK_P) | (1 << GB_LINK_N));
endpackage

// File: rtl/dcbp_tri_carrier.sv
module dcbp_tri_carrier #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             idle,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             at_zero
);
   logic rising;

   always_ff @(posedge clk) begin
      if (idle) begin
         cnt    <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         if (cnt < top) begin
            cnt <= cnt + CNT_W'(1);
         end else if (cnt != '0) begin
            cnt    <= cnt - CNT_W'(1);
            rising <= (cnt == CNT_W'(1));
         end
      end else begin
         cnt <= cnt - CNT_W'(1);
         if (cnt == CNT_W'(1)) rising <= 1'b1;
      end
   end

   assign at_zero = (cnt == '0);
endmodule

// File: rtl/dcbp_ref_capture.sv
module dcbp_ref_capture #(
   parameter int REF_W = 12,
   localparam int MAG_W = REF_W - 1
) (
   input  logic             clk,
   input  logic             idle,
   input  logic             load,
   input  logic [REF_W-1:0] ref_in,
   output logic             pol_neg,
   output logic [MAG_W-1:0] mag
);
   logic             sgn;
   logic             is_min;
   logic [MAG_W-1:0] low;
   logic [MAG_W-1:0] mag_next;

   assign sgn    = ref_in[REF_W-1];
   assign low    = ref_in[MAG_W-1:0];
   assign is_min = sgn && (low == '0);

   always_comb begin
      if (is_min)   mag_next = '1;                  // clip full-scale negative
      else if (sgn) mag_next = ~low + MAG_W'(1);
      else          mag_next = low;
   end

   always_ff @(posedge clk) begin
      if (idle) begin
         pol_neg <= 1'b0;
         mag     <= '0;
      end else if (load) begin
         pol_neg <= sgn;
         mag     <= mag_next;
      end
   end
endmodule

// File: rtl/dcbp_pattern.sv
module dcbp_pattern
   import dcbp_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int MAG_W = 11
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [MAG_W-1:0] mag,
   input  logic             pol_neg,
   output gate_vec_t        want
);
   localparam int CMP_W = (CNT_W > MAG_W) ? CNT_W : MAG_W;

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] mag_x;
   logic             active;

   generate
      if (CNT_W >= MAG_W) begin : g_pad_mag
         assign cnt_x = cnt;
         assign mag_x = {{(CMP_W-MAG_W){1'b0}}, mag};
      end else begin : g_pad_cnt
         assign cnt_x = {{(CMP_W-CNT_W){1'b0}}, cnt};
         assign mag_x = mag;
      end
   endgenerate

   assign active = (mag_x > cnt_x);

   always_comb begin
      if (!active)     want = '0;
      else if (pol_neg) want = SET_NEG;
      else             want = SET_POS;
   end
endmodule

// File: rtl/dcbp_dead_guard.sv
module dcbp_dead_guard
   import dcbp_pkg::*;
#(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            idle,
   input  gate_vec_t       want,
   input  logic [DT_W-1:0] dead_len,
   output gate_vec_t       gate
);
   logic [DT_W-1:0] age;
   logic            drop;
   logic            may_rise;

   // any turn-off opens the whole set
   assign drop     = |(gate & ~want);
   assign may_rise = !drop && (age >= dead_len);

   generate
      for (genvar gi = 0; gi < GATE_N; gi++) begin : g_gate
         always_ff @(posedge clk) begin
            if (idle) gate[gi] <= 1'b0;
            else      gate[gi] <= want[gi] && !drop && (gate[gi] || may_rise);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (idle)               age <= '0;
      else if (drop)          age <= DT_W'(1);
      else if (age != '1)     age <= age + DT_W'(1);
   end
endmodule

// File: rtl/dcbp_gate_seq.sv
module dcbp_gate_seq
   import dcbp_pkg::*;
#(
   parameter int REF_W = 12,
   parameter int CNT_W = 10,
   parameter int DT_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [REF_W-1:0] ref_smp,
   input  logic [CNT_W-1:0] car_top,
   input  logic [DT_W-1:0]  dead_len,
   output logic             g_pos_hi,
   output logic             g_pos_lo,
   output logic             g_neg_hi,
   output logic             g_neg_lo,
   output logic             g_link_p,
   output logic             g_link_n,
   output logic             neg_half
);
   localparam int MAG_W = REF_W - 1;

   generate
      if (REF_W < 3) begin : g_chk_ref
         $error("dcbp_gate_seq: REF_W must be at least 3");
      end
      if (CNT_W < 2) begin : g_chk_cnt
         $error("dcbp_gate_seq: CNT_W must be at least 2");
      end
      if (DT_W < 1) begin : g_chk_dt
         $error("dcbp_gate_seq: DT_W must be at least 1");
      end
   endgenerate

   logic             idle;
   logic [CNT_W-1:0] car_cnt;
   logic             car_zero;
   logic [MAG_W-1:0] mag_q;
   logic             pol_q;
   gate_vec_t        want;
   gate_vec_t        gate_q;

   assign idle = rst || !en;

   dcbp_tri_carrier #(.CNT_W(CNT_W)) i_carrier (
      .clk     (clk),
      .idle    (idle),
      .top     (car_top),
      .cnt     (car_cnt),
      .at_zero (car_zero)
   );

   dcbp_ref_capture #(.REF_W(REF_W)) i_capture (
      .clk     (clk),
      .idle    (idle),
      .load    (car_zero),
      .ref_in  (ref_smp),
      .pol_neg (pol_q),
      .mag     (mag_q)
   );

   dcbp_pattern #(.CNT_W(CNT_W), .MAG_W(MAG_W)) i_pattern (
      .cnt     (car_cnt),
      .mag     (mag_q),
      .pol_neg (pol_q),
      .want    (want)
   );

   dcbp_dead_guard #(.DT_W(DT_W)) i_guard (
      .clk      (clk),
      .idle     (idle),
      .want     (want),
      .dead_len (dead_len),
      .gate     (gate_q)
   );

   assign g_pos_hi = gate_q[GB_POS_HI];
   assign g_pos_lo = gate_q[GB_POS_LO];
   assign g_neg_hi = gate_q[GB_NEG_HI];
   assign g_neg_lo = gate_q[GB_NEG_LO];
   assign g_link_p = gate_q[GB_LINK_P];
   assign g_link_n = gate_q[GB_LINK_N];
   assign neg_half = pol_q;
endmodule

// File: rtl/dcbp_gate_seq_chk.sv
module dcbp_gate_seq_chk #(
   parameter int DT_W = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            en,
   input logic [5:0]      gates,
   input logic            cnt_zero,
   input logic [DT_W-1:0] dead_len,
   input logic            neg_half
);
   logic [5:0]    prev_g;
   logic          seen_off;
   logic [DT_W:0] since_off;
   logic [DT_W:0] need;
   logic          rise_ev;
   logic          fall_ev;

   assign rise_ev = |(gates & ~prev_g);
   assign fall_ev = |(prev_g & ~gates);
   assign need    = (dead_len == '0) ? (DT_W+1)'(1) : {1'b0, dead_len};

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_g    <= '0;
         seen_off  <= 1'b0;
         since_off <= '0;
      end else begin
         prev_g <= gates;
         if (fall_ev) begin
            seen_off  <= 1'b1;
            since_off <= (DT_W+1)'(1);
         end else if (since_off != '1) begin
            since_off <= since_off + (DT_W+1)'(1);
         end
      end
   end

   // R6: diagonals exclusive
   assert_diag_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !((gates[0] || gates[1]) && (gates[2] || gates[3])));

   // R10: rail switches move with a complete diagonal
   assert_link_follow_R10: assert property (@(posedge clk) disable iff (rst)
      (gates[4] == gates[5]) && (gates[0] == gates[1]) && (gates[2] == gates[3]) &&
      (gates[4] == (gates[0] || gates[2])));

   // R8: idle parks every gate low
   assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
      !en |=> (gates == 6'b0 && !neg_half));

   // R5: polarity only moves after a carrier-zero cycle or when idled
   assert_flag_boundary_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(neg_half) |-> ($past(cnt_zero) || !$past(en)));

   // R7: no turn-on together with or too soon after a turn-off
   assert_dead_gap_R7: assert property (@(posedge clk) disable iff (rst)
      rise_ev |-> (!fall_ev && (!seen_off || since_off >= need)));
endmodule

bind dcbp_gate_seq dcbp_gate_seq_chk #(.DT_W(DT_W)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .gates    (gate_q),
   .cnt_zero (car_zero),
   .dead_len (dead_len),
   .neg_half (neg_half)
);

// File: tb/test_dcbp_gate_seq.sv
module test_dcbp_gate_seq;
   localparam int CLK_PERIOD = 10;
   localparam int REF_W = 12;
   localparam int CNT_W = 10;
   localparam int DT_W  = 4;
   localparam int WATCHDOG = 20000;

   logic             clk = 1'b0;
   logic             rst;
   logic             en;
   logic [REF_W-1:0] ref_smp;
   logic [CNT_W-1:0] car_top;
   logic [DT_W-1:0]  dead_len;
   logic g_pos_hi, g_pos_lo, g_neg_hi, g_neg_lo, g_link_p, g_link_n, neg_half;

   dcbp_gate_seq #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) i_dcbp_gate_seq (
      .clk(clk), .rst(rst), .en(en), .ref_smp(ref_smp), .car_top(car_top),
      .dead_len(dead_len), .g_pos_hi(g_pos_hi), .g_pos_lo(g_pos_lo),
      .g_neg_hi(g_neg_hi), .g_neg_lo(g_neg_lo), .g_link_p(g_link_p),
      .g_link_n(g_link_n), .neg_half(neg_half)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit started = 0;

   // behavioural reference state
   int m_cnt, m_up, m_pol, m_mag, m_age;
   int m_g[6];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   function automatic bit in_pos(int b);
      return (b == 0 || b == 1 || b == 4 || b == 5);
   endfunction
   function automatic bit in_neg(int b);
      return (b == 2 || b == 3 || b == 4 || b == 5);
   endfunction

   always @(posedge clk) begin
      int r;
      int want[6];
      bit any_off;
      bit active;
      cyc++;
      started = 1;
      if (rst || !en) begin
         m_cnt = 0; m_up = 1; m_pol = 0; m_mag = 0; m_age = 0;
         for (int b = 0; b < 6; b++) m_g[b] = 0;
      end else begin
         active = (m_mag > m_cnt);
         any_off = 0;
         for (int b = 0; b < 6; b++) begin
            want[b] = active && (m_pol ? in_neg(b) : in_pos(b));
            if (m_g[b] != 0 && want[b] == 0) any_off = 1;
         end
         for (int b = 0; b < 6; b++)
            m_g[b] = (want[b] != 0 && !any_off &&
                      (m_g[b] != 0 || m_age >= int'(dead_len))) ? 1 : 0;
         if (any_off) m_age = 1;
         else if (m_age < 15) m_age++;
         if (m_cnt == 0) begin
            r = $signed(ref_smp);
            m_pol = (r < 0);
            if (r == -2048) m_mag = 2047;
            else m_mag = (r < 0) ? -r : r;
         end
         if (m_up != 0) begin
            if (m_cnt < int'(car_top)) m_cnt++;
            else if (m_cnt != 0) begin
               m_up = (m_cnt == 1);
               m_cnt--;
            end
         end else begin
            if (m_cnt == 1) m_up = 1;
            m_cnt--;
         end
      end
      if (cyc > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         chk({g_pos_lo, g_pos_hi} == {m_g[1][0], m_g[0][0]}, "R2", "positive diagonal",
             {g_pos_lo, g_pos_hi}, m_g[1]*2 + m_g[0]);
         chk({g_neg_lo, g_neg_hi} == {m_g[3][0], m_g[2][0]}, "R3", "negative diagonal",
             {g_neg_lo, g_neg_hi}, m_g[3]*2 + m_g[2]);
         chk({g_link_n, g_link_p} == {m_g[5][0], m_g[4][0]}, "R4", "rail switches",
             {g_link_n, g_link_p}, m_g[5]*2 + m_g[4]);
         chk(neg_half == m_pol[0], "R5", "polarity flag", neg_half, m_pol);
      end
   end

   task automatic tally(input int n, output int c_pos, output int c_neg,
                        output int c_link, output int c_off, output int c_both);
      c_pos = 0; c_neg = 0; c_link = 0; c_off = 0; c_both = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (g_pos_hi) c_pos++;
         if (g_neg_hi) c_neg++;
         if (g_link_p) c_link++;
         if (!(g_pos_hi | g_pos_lo | g_neg_hi | g_neg_lo | g_link_p | g_link_n)) c_off++;
         if ((g_pos_hi | g_pos_lo) && (g_neg_hi | g_neg_lo)) c_both++;
      end
   endtask

   task automatic park_and_set(input int top, input int dead, input int refv);
      @(negedge clk);
      en = 0;
      @(negedge clk);
      chk({g_pos_hi, g_pos_lo, g_neg_hi, g_neg_lo, g_link_p, g_link_n} == 6'b0,
          "R8", "gates while idle",
          {g_pos_hi, g_pos_lo, g_neg_hi, g_neg_lo, g_link_p, g_link_n}, 0);
      chk(neg_half == 1'b0, "R8", "flag while idle", neg_half, 0);
      car_top = CNT_W'(top);
      dead_len = DT_W'(dead);
      ref_smp = REF_W'(refv);
      en = 1;
   endtask

   initial begin
      int cp, cn, cl, co, cb, gap;
      rst = 1; en = 0; ref_smp = '0; car_top = CNT_W'(10); dead_len = '0;
      repeat (3) @(negedge clk);
      chk({g_pos_hi, g_pos_lo, g_neg_hi, g_neg_lo, g_link_p, g_link_n} == 6'b0,
          "R8", "gates in reset",
          {g_pos_hi, g_pos_lo, g_neg_hi, g_neg_lo, g_link_p, g_link_n}, 0);
      chk(neg_half == 1'b0, "R8", "flag in reset", neg_half, 0);
      rst = 0; en = 1; ref_smp = REF_W'(9);
      repeat (60) @(negedge clk);
      // R2: magnitude 9, peak 10, natural gap 3 > dead 0 -> 17 on-cycles
      tally(20, cp, cn, cl, co, cb);
      chk(cp == 17, "R2", "positive on-cycles per period", cp, 17);
      chk(cn == 0, "R3", "negative idle in positive half", cn, 0);
      chk(neg_half == 0, "R5", "flag positive", neg_half, 0);

      // R7: dead time 5 stretches the 3-cycle gap to 5
      park_and_set(10, 5, 9);
      repeat (60) @(negedge clk);
      tally(20, cp, cn, cl, co, cb);
      chk(cp == 15, "R7", "on-cycles with widened gap", cp, 15);
      chk(co == 5, "R7", "all-off cycles per period", co, 5);

      // R1: period of 2T, R4 rails follow the diagonal
      park_and_set(10, 2, 3);
      repeat (60) @(negedge clk);
      while (g_pos_hi) @(negedge clk);
      while (!g_pos_hi) @(negedge clk);
      gap = 0;
      while (g_pos_hi) begin gap++; @(negedge clk); end
      while (!g_pos_hi) begin gap++; @(negedge clk); end
      chk(gap == 20, "R1", "cycles between pulse starts", gap, 20);
      tally(20, cp, cn, cl, co, cb);
      chk(cp == 5, "R2", "on-cycles for magnitude 3", cp, 5);
      chk(cl == 5, "R4", "rail on-cycles match diagonal", cl, 5);

      // R4: zero reference gives no pulse
      ref_smp = '0;
      repeat (60) @(negedge clk);
      tally(20, cp, cn, cl, co, cb);
      chk(cl == 0, "R4", "rail on-cycles at zero reference", cl, 0);
      chk(co == 20, "R4", "all-off cycles at zero reference", co, 20);

      // R3 / R5: negative half
      ref_smp = REF_W'(-4);
      repeat (60) @(negedge clk);
      tally(20, cp, cn, cl, co, cb);
      chk(cn == 7, "R3", "negative on-cycles for magnitude 4", cn, 7);
      chk(cp == 0, "R3", "positive idle in negative half", cp, 0);
      chk(neg_half == 1, "R5", "flag negative", neg_half, 1);

      // R6 / R7: direct change between diagonals at full scale
      ref_smp = REF_W'(20);
      repeat (60) @(negedge clk);
      tally(20, cp, cn, cl, co, cb);
      chk(cp == 20, "R2", "full-scale positive conduction", cp, 20);
      ref_smp = REF_W'(-20);
      tally(80, cp, cn, cl, co, cb);
      chk(cb == 0, "R6", "cycles with both diagonals on", cb, 0);
      chk(co == 2, "R7", "all-off cycles at diagonal change", co, 2);

      // R9: most negative code is full scale
      park_and_set(100, 1, -2048);
      repeat (450) @(negedge clk);
      tally(200, cp, cn, cl, co, cb);
      chk(cn == 200, "R9", "negative conduction at most negative code", cn, 200);
      chk(neg_half == 1, "R9", "flag at most negative code", neg_half, 1);

      // R10: rails equal to diagonal across a mixed run
      park_and_set(10, 0, 6);
      repeat (60) @(negedge clk);
      tally(40, cp, cn, cl, co, cb);
      chk(cl == cp + cn, "R10", "rail cycles equal diagonal cycles", cl, cp + cn);

      finish_run();
   end
endmodule